// File: doc/BRIEF.md
# Legacy Memory Region Router

This block sits beside a small processor bus and decides, for every transaction, where it belongs. A memory access can go to system DRAM, be redirected to a graphics target when it falls in one of the two legacy video windows, or be sent to the external bus. For each access the block also reports whether it may be cached, forces address bit 20 low when that masking is enabled, and raises a system-management interrupt request when a trapped video I/O port is touched.

Two programmable registers control the routing. A top-of-memory register sets the DRAM limit in 128 KB steps. A region-map register holds the window controls, the graphics-redirect enables, the A20 mask enable, the I/O trap enable and a gate that decides whether a PCI-slave requester may reach these registers. Both registers sit behind a 32-bit register port that supports byte enables.

The decode is combinational: its outputs are valid in the same cycle as the request. A register write takes effect on the next clock edge.

Top module: `legacy_region_router`

## Requirements
- R1: After a synchronous active-low reset, offset 0x0 reads 0x0FFFFFFF (limit field all ones) and offset 0x4 reads 0x00000000.
- R2: Bits 31:28 of offset 0x0 read 0 and its bits 16:0 read 1. At offset 0x4 only bits 28:24 and 22:15 hold data, and all other bits read 0. Offsets 0x8 and 0xC read 0.
- R3: A write updates only the bytes whose enable bit is set (cfg_be[i] covers bits 8i+7:8i), and the new value is visible after the next rising clock edge.
- R4: Outside the windows, a memory access at or below the top address {4'b0, limit[10:0], 17'h1FFFF} (limit at bits 27:17 of offset 0x0) asserts route_dram and cacheable. An access above the top asserts route_ext and leaves cacheable low.
- R5: Region-map bit 28 redirects 0xB8000–0xBFFFF to graphics and bit 20 redirects 0xB0000–0xB7FFF. A redirected access asserts route_gfx and never cacheable, whatever the cache bit of that window says.
- R6: When redirect is off, a window uses its 4-bit control field (bits 27:24 for the upper window, 19:16 for the lower). Field bit 0 set asserts route_ext; otherwise route_dram is asserted. cacheable equals field bit 2 AND NOT field bit 0.
- R7: With region-map bit 21 set, out_addr bit 20 is forced to 0 unless req_smi is high, and routing uses the masked address. With the bit clear, out_addr equals req_addr.
- R8: With region-map bit 15 set, a valid I/O access (req_io=1) to ports 0x3D0–0x3DF asserts smi_req in the same cycle. I/O accesses never assert any route output, and memory accesses never assert smi_req.
- R9: When cfg_pci_src is high and region-map bit 22 is clear, a register access asserts cfg_refused, reads 0 and leaves both registers unchanged. With bit 22 set, the access proceeds normally.
- R10: At most one of route_dram, route_gfx and route_ext is high at a time. With req_valid low, all route outputs, cacheable and smi_req are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en | input | 1 | Register port access strobe |
| cfg_wr | input | 1 | 1 = write, 0 = read |
| cfg_pci_src | input | 1 | Access comes from the PCI-slave requester |
| cfg_addr | input | 4 | Register byte offset |
| cfg_be | input | 4 | Byte enables for writes |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data (combinational) |
| cfg_refused | output | 1 | Access refused by the PCI gate |
| req_valid | input | 1 | Bus transaction present |
| req_io | input | 1 | 1 = I/O access, 0 = memory access |
| req_smi | input | 1 | Access made in system-management mode |
| req_addr | input | 32 | Transaction address |
| out_addr | output | 32 | Address after A20 masking |
| route_dram | output | 1 | Access goes to system DRAM |
| route_gfx | output | 1 | Access redirected to graphics |
| route_ext | output | 1 | Access goes to the external bus |
| cacheable | output | 1 | Access may be cached |
| smi_req | output | 1 | System-management interrupt request |

## Verification
A20 masking and window redirection can act in the same cycle. The bench provokes this by sending address 0x1B0000 with masking and lower-window redirect both enabled. It expects out_addr 0xB0000 and route_gfx, which shows that routing is judged on the masked address. The trap and the routing also share a cycle. The bench checks that a trapped port raises smi_req while every memory route stays low, and that a memory access to the same numeric address reaches DRAM with no interrupt request.

// File: rtl/lrr_pkg.sv
// Package: shared constants, types and helpers of the legacy region router.
// Assumes a 32-bit register port with four byte lanes.
package lrr_pkg;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned BE_W   = DATA_W / 8;

    localparam logic [3:0] OFS_TOP = 4'h0;
    localparam logic [3:0] OFS_MAP = 4'h4;

    // Region-map bit positions
    localparam int unsigned MAP_GFX_HI  = 28;
    localparam int unsigned MAP_CTL_HI  = 24;
    localparam int unsigned MAP_PCI     = 22;
    localparam int unsigned MAP_A20     = 21;
    localparam int unsigned MAP_GFX_LO  = 20;
    localparam int unsigned MAP_CTL_LO  = 16;
    localparam int unsigned MAP_TRAP    = 15;
    localparam logic [DATA_W-1:0] MAP_KEEP = 32'h1F7F_8000;

    // Region control field bit meanings
    localparam int unsigned CTL_EXT   = 0;
    localparam int unsigned CTL_CACHE = 2;

    typedef struct packed {
        logic       gfx_en;
        logic [3:0] ctl;
    } win_cfg_t;

    typedef struct packed {
        logic dram;
        logic gfx;
        logic ext;
        logic cache;
    } route_t;

    // Merge new data into old data byte by byte under enables.
    function automatic logic [DATA_W-1:0] be_merge(
        input logic [DATA_W-1:0] old_v,
        input logic [DATA_W-1:0] new_v,
        input logic [BE_W-1:0]   be);
        logic [DATA_W-1:0] r;
        for (int i = 0; i < BE_W; i++) begin
            r[i*8 +: 8] = be[i] ? new_v[i*8 +: 8] : old_v[i*8 +: 8];
        end
        return r;
    endfunction
endpackage

// File: rtl/lrr_cfg_regs.sv
// Module: configuration registers (top-of-memory and region map).
// Holds only the fields that have meaning and rebuilds reserved bits on
// read. Assumes the register port is driven synchronously to clk.
module lrr_cfg_regs
    import lrr_pkg::*;
#(
    parameter int unsigned TOP_W  = 11,
    parameter int unsigned TOP_LO = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic              cfg_wr,
    input  logic              cfg_pci_src,
    input  logic [3:0]        cfg_addr,
    input  logic [BE_W-1:0]   cfg_be,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic              cfg_refused,
    output logic [TOP_W-1:0]  top_field,
    output win_cfg_t          win_lo,
    output win_cfg_t          win_hi,
    output logic              a20_en,
    output logic              trap_en
);
    localparam int unsigned TOP_HI = TOP_LO + TOP_W - 1;
    localparam int unsigned PAD_W  = DATA_W - TOP_HI - 1;

    logic [TOP_W-1:0]  top_q;
    logic [DATA_W-1:0] map_q;
    logic [DATA_W-1:0] top_view;
    logic [DATA_W-1:0] top_next;
    logic              wr_ok;

    // Full view of the top register: zero pad, limit, ones below.
    assign top_view = {{PAD_W{1'b0}}, top_q, {TOP_LO{1'b1}}};
    // Refuse PCI-slave accesses while the gate is closed.
    assign cfg_refused = cfg_en & cfg_pci_src & ~map_q[MAP_PCI];
    assign wr_ok       = cfg_en & cfg_wr & ~cfg_refused;
    assign top_next    = be_merge(top_view, cfg_wdata, cfg_be);

    // Register update with byte enables; reset loads the power-on values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q <= '1;
            map_q <= '0;
        end else if (wr_ok) begin
            if (cfg_addr == OFS_TOP) top_q <= top_next[TOP_HI:TOP_LO];
            if (cfg_addr == OFS_MAP) map_q <= be_merge(map_q, cfg_wdata, cfg_be) & MAP_KEEP;
        end
    end

    // Read mux; unused offsets and refused accesses return zero.
    always_comb begin
        cfg_rdata = '0;
        if (!cfg_refused) begin
            case (cfg_addr)
                OFS_TOP: cfg_rdata = top_view;
                OFS_MAP: cfg_rdata = map_q;
                default: cfg_rdata = '0;
            endcase
        end
    end

    assign top_field = top_q;
    assign win_lo    = '{gfx_en: map_q[MAP_GFX_LO], ctl: map_q[MAP_CTL_LO +: 4]};
    assign win_hi    = '{gfx_en: map_q[MAP_GFX_HI], ctl: map_q[MAP_CTL_HI +: 4]};
    assign a20_en    = map_q[MAP_A20];
    assign trap_en   = map_q[MAP_TRAP];

    // R3: a full-word map write lands on the next edge.
    a_r3_map_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && cfg_addr == OFS_MAP && cfg_be == '1)
        |=> (map_q == ($past(cfg_wdata) & MAP_KEEP)));

    // R9: a refused access leaves both registers unchanged.
    a_r9_refused_holds: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_refused |=> ($stable(map_q) && $stable(top_q)));
endmodule

// File: rtl/lrr_mem_route.sv
// Module: memory-side decode. Applies the A20 mask, then classifies the
// access against the two legacy video windows and the DRAM limit.
// Assumes the windows lie in the low megabyte and do not overlap.
module lrr_mem_route
    import lrr_pkg::*;
#(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned TOP_W   = 11,
    parameter int unsigned TOP_LO  = 17,
    parameter int unsigned WIN_N   = 2,
    parameter int unsigned WIN_LOG = 15,
    parameter logic [ADDR_W-1:0] WIN_BASE = 32'h000B_0000,
    parameter int unsigned A20_BIT = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_io,
    input  logic              req_smi,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [TOP_W-1:0]  top_field,
    input  win_cfg_t          win_cfg [WIN_N],
    input  logic              a20_en,
    output route_t            route,
    output logic [ADDR_W-1:0] out_addr
);
    localparam int unsigned PAD_W = ADDR_W - TOP_W - TOP_LO;

    logic [ADDR_W-1:0] addr_m;
    logic [ADDR_W-1:0] top_addr;
    logic [WIN_N-1:0]  win_hit;
    logic              below_top;
    logic              mem_ok;

    // A20 masking bypassed in management mode.
    always_comb begin
        addr_m = req_addr;
        if (a20_en && !req_smi) addr_m[A20_BIT] = 1'b0;
    end

    assign top_addr  = {{PAD_W{1'b0}}, top_field, {TOP_LO{1'b1}}};
    assign below_top = (addr_m <= top_addr);
    assign mem_ok    = req_valid & ~req_io;

    // One range comparator per window.
    for (genvar w = 0; w < WIN_N; w++) begin : g_win
        localparam logic [ADDR_W-1:0] LO = WIN_BASE + (ADDR_W'(w) << WIN_LOG);
        localparam logic [ADDR_W-1:0] HI = LO + ((ADDR_W'(1) << WIN_LOG) - 1);
        assign win_hit[w] = (addr_m >= LO) && (addr_m <= HI);
    end

    // Route selection: window redirect, window control, then DRAM limit.
    always_comb begin
        route = '0;
        if (mem_ok) begin
            if (win_hit != '0) begin
                for (int w = 0; w < WIN_N; w++) begin
                    if (win_hit[w]) begin
                        if (win_cfg[w].gfx_en) begin
                            route.gfx = 1'b1;
                        end else begin
                            route.ext   = win_cfg[w].ctl[CTL_EXT];
                            route.dram  = ~win_cfg[w].ctl[CTL_EXT];
                            route.cache = win_cfg[w].ctl[CTL_CACHE] & ~win_cfg[w].ctl[CTL_EXT];
                        end
                    end
                end
            end else begin
                route.dram  = below_top;
                route.cache = below_top;
                route.ext   = ~below_top;
            end
        end
    end

    assign out_addr = addr_m;

    // R5: graphics traffic is never cacheable.
    a_r5_gfx_uncached: assert property (@(posedge clk) disable iff (!rst_n)
        route.gfx |-> !route.cache);
    // R10: at most one target per access.
    a_r10_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({route.dram, route.gfx, route.ext}));
    // R10: no routing without a request.
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (route == '0));
    // R7: masked bit stays low outside management mode.
    a_r7_a20_forced: assert property (@(posedge clk) disable iff (!rst_n)
        (a20_en && !req_smi) |-> !out_addr[A20_BIT]);
endmodule

// File: rtl/lrr_io_trap.sv
// Module: I/O port trap. Flags valid I/O accesses that hit a fixed port
// range when trapping is enabled. Assumes the range is aligned to its size.
module lrr_io_trap #(
    parameter int unsigned ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] TRAP_BASE = 32'h0000_03D0,
    parameter int unsigned TRAP_SPAN = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_io,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              trap_en,
    output logic              smi_req
);
    localparam logic [ADDR_W-1:0] TRAP_LAST = TRAP_BASE + ADDR_W'(TRAP_SPAN - 1);

    logic in_range;

    // Range compare on the unmasked port number.
    assign in_range = (req_addr >= TRAP_BASE) && (req_addr <= TRAP_LAST);
    // Request lasts exactly as long as the trapped access.
    assign smi_req  = req_valid & req_io & trap_en & in_range;

    // R8: the trap only answers enabled I/O traffic.
    a_r8_trap_io_only: assert property (@(posedge clk) disable iff (!rst_n)
        smi_req |-> (req_io && trap_en && req_valid));
endmodule

// File: rtl/legacy_region_router.sv
// Module: top of the legacy region router. Joins the configuration
// registers, the memory decode and the I/O trap. All decode outputs are
// combinational from the request and the current register state.
module legacy_region_router
    import lrr_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned TOP_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic              cfg_wr,
    input  logic              cfg_pci_src,
    input  logic [3:0]        cfg_addr,
    input  logic [3:0]        cfg_be,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic              cfg_refused,
    input  logic              req_valid,
    input  logic              req_io,
    input  logic              req_smi,
    input  logic [ADDR_W-1:0] req_addr,
    output logic [ADDR_W-1:0] out_addr,
    output logic              route_dram,
    output logic              route_gfx,
    output logic              route_ext,
    output logic              cacheable,
    output logic              smi_req
);
    logic [TOP_W-1:0] top_field;
    win_cfg_t         win_lo;
    win_cfg_t         win_hi;
    win_cfg_t         win_cfg [2];
    logic             a20_en;
    logic             trap_en;
    route_t           route;

    lrr_cfg_regs #(.TOP_W(TOP_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_en(cfg_en), .cfg_wr(cfg_wr), .cfg_pci_src(cfg_pci_src),
        .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .cfg_refused(cfg_refused),
        .top_field(top_field), .win_lo(win_lo), .win_hi(win_hi),
        .a20_en(a20_en), .trap_en(trap_en)
    );

    // Window order follows address order: lower window first.
    assign win_cfg[0] = win_lo;
    assign win_cfg[1] = win_hi;

    lrr_mem_route #(.ADDR_W(ADDR_W), .TOP_W(TOP_W)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_io(req_io), .req_smi(req_smi),
        .req_addr(req_addr), .top_field(top_field), .win_cfg(win_cfg),
        .a20_en(a20_en), .route(route), .out_addr(out_addr)
    );

    lrr_io_trap #(.ADDR_W(ADDR_W)) u_trap (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_io(req_io), .req_addr(req_addr),
        .trap_en(trap_en), .smi_req(smi_req)
    );

    assign route_dram = route.dram;
    assign route_gfx  = route.gfx;
    assign route_ext  = route.ext;
    assign cacheable  = route.cache;

    // R8: trapped I/O never reaches a memory target.
    a_r8_io_not_routed: assert property (@(posedge clk) disable iff (!rst_n)
        smi_req |-> !(route_dram || route_gfx || route_ext));
endmodule

// File: tb/legacy_region_router_tb.sv
module legacy_region_router_tb;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [31:0] map;
        logic [10:0] topf;
        logic        io;
        logic        smi;
        logic [31:0] addr;
        logic [4:0]  expv;   // {dram, gfx, ext, cache, smi}
        logic [31:0] eaddr;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VECS [NV] = '{
        '{32'h0,        11'h7FF, 1'b0, 1'b0, 32'h000AFFFF, 5'b10010, 32'h000AFFFF, 4'd4}, // R4 below window
        '{32'h0,        11'h7FF, 1'b0, 1'b0, 32'h000B0000, 5'b10000, 32'h000B0000, 4'd6}, // R6 ctl 0
        '{32'h00040000, 11'h7FF, 1'b0, 1'b0, 32'h000B0000, 5'b10010, 32'h000B0000, 4'd6}, // R6 cache bit
        '{32'h00040000, 11'h7FF, 1'b0, 1'b0, 32'h000B7FFF, 5'b10010, 32'h000B7FFF, 4'd6}, // R6 lower edge
        '{32'h00040000, 11'h7FF, 1'b0, 1'b0, 32'h000B8000, 5'b10000, 32'h000B8000, 4'd6}, // R6 upper window
        '{32'h00140000, 11'h7FF, 1'b0, 1'b0, 32'h000B0000, 5'b01000, 32'h000B0000, 4'd5}, // R5 lower gfx
        '{32'h00140000, 11'h7FF, 1'b0, 1'b0, 32'h000AFFFF, 5'b10010, 32'h000AFFFF, 4'd5}, // R5 outside
        '{32'h00140000, 11'h7FF, 1'b0, 1'b0, 32'h000B8000, 5'b10000, 32'h000B8000, 4'd5}, // R5 other window
        '{32'h14000000, 11'h7FF, 1'b0, 1'b0, 32'h000BFFFF, 5'b01000, 32'h000BFFFF, 4'd5}, // R5 upper gfx
        '{32'h14000000, 11'h7FF, 1'b0, 1'b0, 32'h000C0000, 5'b10010, 32'h000C0000, 4'd5}, // R5 past window
        '{32'h14000000, 11'h7FF, 1'b0, 1'b0, 32'h000B7FFF, 5'b10000, 32'h000B7FFF, 4'd5}, // R5 lower not gfx
        '{32'h01000000, 11'h7FF, 1'b0, 1'b0, 32'h000B8000, 5'b00100, 32'h000B8000, 4'd6}, // R6 external
        '{32'h05000000, 11'h7FF, 1'b0, 1'b0, 32'h000BC000, 5'b00100, 32'h000BC000, 4'd6}, // R6 ext uncached
        '{32'h0,        11'h000, 1'b0, 1'b0, 32'h0001FFFF, 5'b10010, 32'h0001FFFF, 4'd4}, // R4 min top
        '{32'h0,        11'h000, 1'b0, 1'b0, 32'h00020000, 5'b00100, 32'h00020000, 4'd4}, // R4 min top +1
        '{32'h0,        11'h010, 1'b0, 1'b0, 32'h0021FFFF, 5'b10010, 32'h0021FFFF, 4'd4}, // R4 mid top
        '{32'h0,        11'h010, 1'b0, 1'b0, 32'h00220000, 5'b00100, 32'h00220000, 4'd4}, // R4 mid top +1
        '{32'h0,        11'h7FF, 1'b0, 1'b0, 32'h0FFFFFFF, 5'b10010, 32'h0FFFFFFF, 4'd4}, // R4 max top
        '{32'h0,        11'h7FF, 1'b0, 1'b0, 32'h10000000, 5'b00100, 32'h10000000, 4'd4}, // R4 max top +1
        '{32'h00200000, 11'h7FF, 1'b0, 1'b0, 32'h00100000, 5'b10010, 32'h00000000, 4'd7}, // R7 masked
        '{32'h00200000, 11'h7FF, 1'b0, 1'b1, 32'h00100000, 5'b10010, 32'h00100000, 4'd7}, // R7 smi bypass
        '{32'h00300000, 11'h7FF, 1'b0, 1'b0, 32'h001B0000, 5'b01000, 32'h000B0000, 4'd7}, // R7 mask into window
        '{32'h00008000, 11'h7FF, 1'b1, 1'b0, 32'h000003CF, 5'b00000, 32'h000003CF, 4'd8}, // R8 below range
        '{32'h00008000, 11'h7FF, 1'b1, 1'b0, 32'h000003D0, 5'b00001, 32'h000003D0, 4'd8}, // R8 first port
        '{32'h00008000, 11'h7FF, 1'b1, 1'b0, 32'h000003DF, 5'b00001, 32'h000003DF, 4'd8}, // R8 last port
        '{32'h00008000, 11'h7FF, 1'b1, 1'b0, 32'h000003E0, 5'b00000, 32'h000003E0, 4'd8}, // R8 above range
        '{32'h0,        11'h7FF, 1'b1, 1'b0, 32'h000003D5, 5'b00000, 32'h000003D5, 4'd8}, // R8 disabled
        '{32'h00008000, 11'h7FF, 1'b0, 1'b0, 32'h000003D5, 5'b10010, 32'h000003D5, 4'd8}  // R8 memory side
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_en = 1'b0, cfg_wr = 1'b0, cfg_pci_src = 1'b0;
    logic [3:0]  cfg_addr = '0, cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        cfg_refused;
    logic        req_valid = 1'b0, req_io = 1'b0, req_smi = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] out_addr;
    logic        route_dram, route_gfx, route_ext, cacheable, smi_req;

    int n_chk = 0;
    int n_bad = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    legacy_region_router u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_en(cfg_en), .cfg_wr(cfg_wr), .cfg_pci_src(cfg_pci_src),
        .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .cfg_refused(cfg_refused),
        .req_valid(req_valid), .req_io(req_io), .req_smi(req_smi),
        .req_addr(req_addr), .out_addr(out_addr),
        .route_dram(route_dram), .route_gfx(route_gfx), .route_ext(route_ext),
        .cacheable(cacheable), .smi_req(smi_req)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic cfg_write(input logic [3:0] a, input logic [3:0] be,
                             input logic [31:0] d, input logic pci);
        @(negedge clk);
        cfg_en = 1'b1; cfg_wr = 1'b1; cfg_addr = a; cfg_be = be;
        cfg_wdata = d; cfg_pci_src = pci;
        @(negedge clk);
        cfg_en = 1'b0; cfg_wr = 1'b0; cfg_pci_src = 1'b0;
    endtask

    task automatic cfg_read(input logic [3:0] a, input logic pci, output logic [31:0] d);
        @(negedge clk);
        cfg_en = 1'b1; cfg_wr = 1'b0; cfg_addr = a; cfg_pci_src = pci;
        #1 d = cfg_rdata;
        cfg_en = 1'b0; cfg_pci_src = 1'b0;
    endtask

    function automatic logic [31:0] outs();
        return {27'd0, route_dram, route_gfx, route_ext, cacheable, smi_req};
    endfunction

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog got=hung exp=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        cfg_read(4'h0, 1'b0, rd); chk("R1 top reset", rd, 32'h0FFFFFFF);
        cfg_read(4'h4, 1'b0, rd); chk("R1 map reset", rd, 32'h00000000);

        // R10 idle request produces nothing
        @(negedge clk);
        req_valid = 1'b0; req_io = 1'b0; req_addr = 32'h00001000;
        #1 chk("R10 idle outputs", outs(), 32'h0);

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            cfg_write(4'h0, 4'hF, {4'h0, VECS[i].topf, 17'h0}, 1'b0);
            cfg_write(4'h4, 4'hF, VECS[i].map, 1'b0);
            @(negedge clk);
            req_valid = 1'b1; req_io = VECS[i].io; req_smi = VECS[i].smi;
            req_addr = VECS[i].addr;
            #1;
            chk($sformatf("R%0d vec%0d route", VECS[i].req, i), outs(), {27'd0, VECS[i].expv});
            chk($sformatf("R%0d vec%0d addr", VECS[i].req, i), out_addr, VECS[i].eaddr);
            req_valid = 1'b0; req_smi = 1'b0;
        end

        // R2 reserved bits after writing all ones
        cfg_write(4'h0, 4'hF, 32'hFFFFFFFF, 1'b0);
        cfg_write(4'h4, 4'hF, 32'hFFFFFFFF, 1'b0);
        cfg_read(4'h0, 1'b0, rd); chk("R2 top reserved", rd, 32'h0FFFFFFF);
        cfg_read(4'h4, 1'b0, rd); chk("R2 map reserved", rd, 32'h1F7F8000);
        cfg_write(4'h8, 4'hF, 32'hFFFFFFFF, 1'b0);
        cfg_read(4'h8, 1'b0, rd); chk("R2 offset 8", rd, 32'h0);
        cfg_read(4'hC, 1'b0, rd); chk("R2 offset C", rd, 32'h0);

        // R3 byte enables
        cfg_write(4'h0, 4'b0100, 32'h00000000, 1'b0);
        cfg_read(4'h0, 1'b0, rd); chk("R3 top byte2", rd, 32'h0F01FFFF);
        cfg_write(4'h4, 4'hF, 32'h0, 1'b0);
        cfg_write(4'h4, 4'b1000, 32'hFFFFFFFF, 1'b0);
        cfg_read(4'h4, 1'b0, rd); chk("R3 map byte3", rd, 32'h1F000000);

        // R9 PCI gate closed
        cfg_write(4'h4, 4'hF, 32'h0, 1'b0);
        @(negedge clk);
        cfg_en = 1'b1; cfg_wr = 1'b1; cfg_addr = 4'h4; cfg_be = 4'hF;
        cfg_wdata = 32'h00408000; cfg_pci_src = 1'b1;
        #1 chk("R9 refused flag", {31'd0, cfg_refused}, 32'h1);
        @(negedge clk);
        cfg_en = 1'b0; cfg_wr = 1'b0; cfg_pci_src = 1'b0;
        cfg_read(4'h4, 1'b1, rd); chk("R9 refused read", rd, 32'h0);
        cfg_read(4'h4, 1'b0, rd); chk("R9 write ignored", rd, 32'h0);
        // R9 PCI gate open
        cfg_write(4'h4, 4'hF, 32'h00400000, 1'b0);
        @(negedge clk);
        cfg_en = 1'b1; cfg_wr = 1'b0; cfg_addr = 4'h4; cfg_pci_src = 1'b1;
        #1 chk("R9 gate open flag", {31'd0, cfg_refused}, 32'h0);
        chk("R9 gate open read", cfg_rdata, 32'h00400000);
        cfg_en = 1'b0; cfg_pci_src = 1'b0;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule